// File: doc/BRIEF.md
# Phase-Safe Reference Clock Selector

This block picks one of two free-running reference clocks, A and B, and passes the picked one to a single output. A one-bit selection command arrives from reference selection logic upstream. A configuration bit, written through a small byte-wide register port, decides how a change of selection is applied. In immediate mode the output switches on the next clock edge, wherever the two references' edges fall. In aligned mode a requested change waits until the newly chosen reference shows a rising edge. Because the switch lands on such an edge, it cannot cut a high phase short, so no runt high pulse appears when the two references are out of phase.

Both references are oversampled by the block clock. Each one passes through a synchronizer of `SYNC_STAGES` flops and then an edge detector. A four-state machine holds the active input. Its states are `ST_ON_A` and `ST_ON_B` (an input is active and no change is pending), and `ST_WAIT_B` and `ST_WAIT_A` (a change toward the named input is pending). The transitions are these. *request* goes from ON to WAIT when the command differs from the active input, aligned mode is set and the target has no rising edge. *commit* goes from WAIT to the target's ON state, on a target rising edge or as soon as aligned mode is cleared. *direct* goes from ON to the other ON state, in immediate mode or when a target edge arrives in the same cycle as the command. *withdraw* goes from WAIT back to the current ON state when the command returns before the edge. The output and the status bit are both registered, and both change on the same edge as the state.

Top module: `refclk_switchover`

## Requirements
- R1: While reset is held, and on the first clock edge after it is released, `active_b` and `ref_out` are 0. Input A is active and immediate mode is set.
- R2: A write with `wr_en` high and `wr_addr` equal to `CFG_ADDR` (default 0x1C1) loads the mode bit from `wr_data` bit `EN_BIT` (default 4), where 1 means aligned. The new mode takes effect from the following edge. Writes to any other address, and all other data bits, leave the mode unchanged.
- R3: The command `sel_b` and the status `active_b` both use 0 for input A and 1 for input B. In immediate mode, when `sel_b` differs from `active_b` at a clock edge, `active_b` takes the value of `sel_b` at that edge.
- R4: In aligned mode, `active_b` changes only at an edge where the synchronized copy of the commanded input shows a rising edge. That copy has gone high, after `SYNC_STAGES` flops, while its previous value was low.
- R5: In aligned mode, if `sel_b` returns to the active input before the rising edge arrives, the pending change is dropped and `active_b` does not change.
- R6: After every edge, `ref_out` equals the value of the input named by the new `active_b`, as that input stood `SYNC_STAGES` edges earlier.
- R7: In aligned mode, with both references running at a steady period, every high interval of `ref_out` lasts at least as long as the shorter high phase of the two references.
- R8: If aligned mode is cleared while a change is pending and `sel_b` still asks for it, the change completes on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples both references |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | Reference input A |
| ref_b | input | 1 | Reference input B |
| sel_b | input | 1 | Selection command: 0 for A, 1 for B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| ref_out | output | 1 | Selected reference, registered |
| active_b | output | 1 | Active input: 0 for A, 1 for B |

## Verification
The bench drives two references at the same period with a chosen phase offset. It changes the offset while a run is in progress and compares every cycle against a model written from the requirements. A design that switched on the command rather than on a target edge in aligned mode would either flip status too early or cut a high phase short, and the high-interval measurement would catch it. A command withdrawn within a few cycles, after the target edge has already passed the synchronizer, exposes a design that latches the request and switches anyway. A write to a neighbouring address with every data bit set exposes a loose address decode. Clearing aligned mode while a change is pending exposes a design that stays stuck in its wait state. A late or early registered output would break the fixed lag between an input and `ref_out`.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    // Bit 1 of the encoding marks input B as the active one.
    typedef enum logic [1:0] {
        ST_ON_A   = 2'b00,
        ST_WAIT_B = 2'b01,
        ST_ON_B   = 2'b11,
        ST_WAIT_A = 2'b10
    } refsw_state_e;

    function automatic logic state_is_b(refsw_state_e s);
        return (s == ST_ON_B) || (s == ST_WAIT_A);
    endfunction

endpackage

// File: rtl/refsw_edge.sv
module refsw_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= ref_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], ref_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/refsw_cfg.sv
module refsw_cfg #(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h1C1,
    parameter int                EN_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cond_en
);

    logic hit;
    logic unused_data;

    assign hit         = wr_en && (wr_addr == CFG_ADDR);
    assign unused_data = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cond_en <= 1'b0;
        else if (hit) cond_en <= wr_data[EN_BIT];
    end

    // R2: traffic to other addresses must not disturb the mode bit
    p_foreign_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != CFG_ADDR)) |=> $stable(cond_en));

endmodule

// File: rtl/refsw_fsm.sv
module refsw_fsm
    import refsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_en,
    input  logic sel_b,
    input  logic lvl_a,
    input  logic lvl_b,
    input  logic rise_a,
    input  logic rise_b,
    output logic ref_out,
    output logic active_b
);

    refsw_state_e state_q, state_d;
    logic         go_b, go_a;

    // A target may be taken when unconditioned, or on its own rising edge.
    assign go_b = !cond_en || rise_b;
    assign go_a = !cond_en || rise_a;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON_A: begin
                if (sel_b) state_d = go_b ? ST_ON_B : ST_WAIT_B;
            end
            ST_WAIT_B: begin
                if (!sel_b)    state_d = ST_ON_A;
                else if (go_b) state_d = ST_ON_B;
            end
            ST_ON_B: begin
                if (!sel_b) state_d = go_a ? ST_ON_A : ST_WAIT_A;
            end
            ST_WAIT_A: begin
                if (sel_b)     state_d = ST_ON_B;
                else if (go_a) state_d = ST_ON_A;
            end
            default: state_d = ST_ON_A;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ON_A;
        else        state_q <= state_d;
    end

    // Output register: mux follows the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_out <= 1'b0;
        else        ref_out <= state_is_b(state_d) ? lvl_b : lvl_a;
    end

    assign active_b = state_is_b(state_q);

    // R4: in aligned mode a move to B needs a synchronized B rising edge
    p_b_waits_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active_b) && $past(cond_en)) |-> $past(rise_b));

    // R4: same rule for a move back to A
    p_a_waits_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active_b) && $past(cond_en)) |-> $past(rise_a));

    // R3: immediate mode follows the command one edge later
    p_direct_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_en && (sel_b != active_b)) |=> (active_b == $past(sel_b)));

    // R5: a withdrawn request returns to the current input
    p_withdraw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_B && !sel_b) |=> (state_q == ST_ON_A));

    // R8: clearing aligned mode releases a pending change
    p_bypass_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_B && sel_b && !cond_en) |=> (state_q == ST_ON_B));

endmodule

// File: rtl/refclk_switchover.sv
module refclk_switchover #(
    parameter int                ADDR_W      = 12,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = 12'h1C1,
    parameter int                EN_BIT      = 4,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_a,
    input  logic              ref_b,
    input  logic              sel_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ref_out,
    output logic              active_b
);

    logic cond_en;
    logic lvl_a, lvl_b, rise_a, rise_b;

    refsw_cfg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CFG_ADDR(CFG_ADDR),
        .EN_BIT  (EN_BIT)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cond_en(cond_en)
    );

    refsw_edge #(.STAGES(SYNC_STAGES)) u_edge_a (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_in(ref_a),
        .level (lvl_a),
        .rise  (rise_a)
    );

    refsw_edge #(.STAGES(SYNC_STAGES)) u_edge_b (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_in(ref_b),
        .level (lvl_b),
        .rise  (rise_b)
    );

    refsw_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_en (cond_en),
        .sel_b   (sel_b),
        .lvl_a   (lvl_a),
        .lvl_b   (lvl_b),
        .rise_a  (rise_a),
        .rise_b  (rise_b),
        .ref_out (ref_out),
        .active_b(active_b)
    );

    // R1: leaving reset, input A is active and the output is low
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!active_b && !ref_out));

endmodule

// File: tb/refclk_switchover_bench.sv
module refclk_switchover_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          L          = 2;
    localparam int          REF_PERIOD = 16;
    localparam int          HALF       = REF_PERIOD / 2;
    localparam int          SETTLE     = REF_PERIOD + L + 4;
    localparam logic [11:0] CFG        = 12'h1C1;
    localparam int          NVEC       = 10;
    // {aligned, phase offset, dwell cycles, withdraw cycle (0 = none)}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'd5,  8'd48, 8'd0},
        {1'b1, 8'd5,  8'd48, 8'd0},
        {1'b1, 8'd11, 8'd48, 8'd0},
        {1'b1, 8'd11, 8'd48, 8'd0},
        {1'b0, 8'd3,  8'd12, 8'd0},
        {1'b0, 8'd13, 8'd12, 8'd0},
        {1'b1, 8'd0,  8'd48, 8'd0},
        {1'b1, 8'd7,  8'd48, 8'd0},
        {1'b1, 8'd12, 8'd48, 8'd3},
        {1'b0, 8'd9,  8'd12, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_a = 1'b0, ref_b = 1'b0, sel_b = 1'b0, wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ref_out, active_b;

    int   errors = 0, checks = 0, cyc = 0, off = 0, settle = 0, run_len = 0;
    logic run_ok = 1'b0;
    logic d_rst = 1'b0, d_sel = 1'b0, d_wr = 1'b0;
    logic [11:0] d_addr = '0;
    logic [7:0]  d_data = '0;
    logic ha [0:L+1];
    logic hb [0:L+1];
    logic m_act = 1'b0, m_out = 1'b0, m_cond = 1'b0, tag_cond = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refclk_switchover #(.SYNC_STAGES(L)) u_refclk_switchover (
        .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .sel_b(sel_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_out(ref_out), .active_b(active_b)
    );

    function automatic logic wave(int c, int o);
        return ((c + REF_PERIOD * 16 - o) % REF_PERIOD) < HALF;
    endfunction

    task automatic check(logic ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        logic ra, rb;
        @(negedge clk);
        if (rst_n) begin
            check(active_b === m_act, tag_cond ? "R4 aligned status" : "R3 immediate status",
                  active_b, m_act);
            check(ref_out === m_out, "R6 output lag", ref_out, m_out);
        end
        if (ref_out === 1'b1) begin
            run_len++;
            if (!m_cond || settle > 0 || !rst_n) run_ok = 1'b0;
        end else begin
            if (run_len > 0 && run_ok) check(run_len >= HALF, "R7 high interval", run_len, HALF);
            run_len = 0;
            run_ok  = 1'b1;
        end
        cyc++;
        rst_n = d_rst;  sel_b = d_sel;  wr_en = d_wr;  wr_addr = d_addr;  wr_data = d_data;
        ref_a = wave(cyc, 0);
        ref_b = wave(cyc, off);
        if (!d_rst) begin
            for (int k = 0; k <= L + 1; k++) begin ha[k] = 1'b0; hb[k] = 1'b0; end
            m_act = 1'b0; m_out = 1'b0; m_cond = 1'b0; tag_cond = 1'b0;
        end else begin
            for (int k = L + 1; k > 0; k--) begin ha[k] = ha[k-1]; hb[k] = hb[k-1]; end
            ha[0] = ref_a;  hb[0] = ref_b;
            ra = ha[L] & ~ha[L+1];
            rb = hb[L] & ~hb[L+1];
            tag_cond = m_cond;
            if (sel_b != m_act && (!m_cond || (sel_b ? rb : ra))) m_act = sel_b;
            m_out = m_act ? hb[L] : ha[L];
            if (wr_en && wr_addr == CFG) m_cond = wr_data[4];
        end
        if (settle > 0) settle--;
        d_wr = 1'b0;
    endtask

    task automatic write_cfg(logic [11:0] a, logic [7:0] d);
        d_wr = 1'b1;  d_addr = a;  d_data = d;
        tick();
    endtask

    // Wait until the bench's own drive of the target input has just risen,
    // then let that edge clear the synchronizer.
    task automatic after_target_rise(logic tgt);
        for (int g = 0; g < 4 * REF_PERIOD; g++) begin
            tick();
            if (tgt ? (hb[0] && !hb[1]) : (ha[0] && !ha[1])) break;
        end
        for (int g = 0; g < L + 2; g++) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;  checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k <= L + 1; k++) begin ha[k] = 1'b0; hb[k] = 1'b0; end
        // R1: reset state
        for (int i = 0; i < 3; i++) tick();
        check(active_b === 1'b0, "R1 status in reset", active_b, 0);
        check(ref_out === 1'b0, "R1 output in reset", ref_out, 0);
        d_rst = 1'b1;
        tick();  tick();
        check(active_b === 1'b0, "R1 status after reset", active_b, 0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            off    = int'(VEC[v][23:16]);
            settle = SETTLE;
            write_cfg(CFG, VEC[v][24] ? 8'h10 : 8'h00);
            d_sel = ~d_sel;
            for (int k = 0; k < int'(VEC[v][15:8]); k++) begin
                if (VEC[v][7:0] != 8'd0 && k == int'(VEC[v][7:0])) d_sel = ~d_sel;
                tick();
            end
        end

        // R2: foreign address and stray data bits leave immediate mode set
        write_cfg(CFG, 8'h00);
        write_cfg(CFG + 12'd1, 8'hFF);
        write_cfg(CFG, 8'hEF);
        d_sel = ~active_b;
        tick();  tick();
        check(active_b === d_sel, "R2 mode kept immediate", active_b, d_sel);

        // R5: withdraw a pending aligned request
        off = 8;  settle = SETTLE;
        write_cfg(CFG, 8'h10);
        for (int i = 0; i < 40; i++) tick();
        begin
            logic keep;
            keep = active_b;
            after_target_rise(~keep);
            d_sel = ~keep;
            for (int i = 0; i < 4; i++) tick();
            d_sel = keep;
            for (int i = 0; i < 20; i++) tick();
            check(active_b === keep, "R5 withdrawn request", active_b, keep);
        end

        // R8: clearing aligned mode releases a pending change
        begin
            logic tgt;
            tgt = ~active_b;
            after_target_rise(tgt);
            d_sel = tgt;
            tick();  tick();
            check(active_b !== tgt, "R8 still pending", active_b, ~tgt);
            write_cfg(CFG, 8'h00);
            tick();  tick();
            check(active_b === tgt, "R8 released", active_b, tgt);
        end

        // R1: reset while input B is active
        d_sel = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        d_rst = 1'b0;
        tick();  tick();
        check(active_b === 1'b0, "R1 mid-run reset status", active_b, 0);
        check(ref_out === 1'b0, "R1 mid-run reset output", ref_out, 0);
        d_sel = 1'b0;  d_rst = 1'b1;
        for (int i = 0; i < 6; i++) tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule